// File: doc/BRIEF.md
# Frame Buffer Fetch Sequencer

This block drives the memory reads that keep a display supplied with data. Once enabled it fetches a colour palette, a stream of pixel words, or the palette followed by the pixel stream. The pixel stream comes from one frame buffer or alternates between two. Each region is given as a first word address and an inclusive last word address. The block cuts every region into read bursts of a configured length. It presents each burst on a request/grant memory port and forwards every returned word to a downstream FIFO write port.

A status vector records the end of each buffer, the completion of the palette load, FIFO underflow and loss of sync. Each of these bits is cleared by writing a one to it. A single interrupt line is the OR of the status bits whose enables are set. Memory, FIFO storage, palette decoding and video timing lie outside the block. Addresses count 32-bit words.

Top module: `fb_fetch_seq`

## Requirements
- R1: `cfg_load_mode` selects the loading phase. Code 0 fetches the palette and then pixel data. Code 1 fetches only the palette and then issues no further request while enable stays high. Code 2 fetches data only. Code 3 behaves as code 2.
- R2: A region is read once in ascending word order from its first address to its inclusive last address. Every returned word is pushed to the FIFO port unchanged and in arrival order.
- R3: `cfg_burst` codes 0, 1, 2, 3 and 4 give bursts of 1, 2, 4, 8 and 16 words. With a code of 5 to 7 no request is issued.
- R4: A burst never passes the region's last address. The final burst of a region is shortened so that it ends exactly there.
- R5: With `cfg_dual` set, data regions alternate between buffer 0 and buffer 1, starting with buffer 0. With it clear, fetching restarts at buffer 0's first address after every end of buffer.
- R6: The end of buffer 0 sets status bit 8. The end of buffer 1 sets status bit 9. The end of the palette sets status bit 6.
- R7: A high `fifo_underflow` sets status bit 5 at the next edge. A high `sync_lost` sets status bit 2 at the next edge.
- R8: A write with `st_clr_we` clears every status bit whose `st_clr_data` bit is 1 and leaves the other bits unchanged. A set event in the same cycle wins over the clear.
- R9: `irq` is high while any enabled status bit is set. `ie_pal` enables bit 6, `ie_eof` enables bits 8 and 9, `ie_urun` enables bit 5 and `ie_sync` enables bit 2.
- R10: The palette region starts at `pal_base`. It is 8 words (32 bytes) long with `cfg_pal8` low and 128 words (512 bytes) long with `cfg_pal8` high.
- R11: No request is made until `cfg_en` is high. When `cfg_en` is sampled low, the next cycle has no request and no FIFO push, and words still arriving are dropped.
- R12: After reset, `status`, `irq`, `mem_req` and `fifo_push` are all 0.
- R13: An ungranted request keeps `mem_req`, `mem_addr` and `mem_len` unchanged until it is granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | 1 | Sequencer enable, set after all other controls |
| cfg_load_mode | input | 2 | Loading phase select |
| cfg_burst | input | 3 | Burst length code |
| cfg_dual | input | 1 | Alternate between the two data buffers |
| cfg_pal8 | input | 1 | Long (128-word) palette select |
| ie_pal | input | 1 | Interrupt enable for palette done |
| ie_eof | input | 1 | Interrupt enable for end of buffer |
| ie_urun | input | 1 | Interrupt enable for underflow |
| ie_sync | input | 1 | Interrupt enable for sync loss |
| pal_base | input | AW | Palette first word address |
| base0 | input | AW | Buffer 0 first word address |
| ceil0 | input | AW | Buffer 0 last word address |
| base1 | input | AW | Buffer 1 first word address |
| ceil1 | input | AW | Buffer 1 last word address |
| fifo_underflow | input | 1 | Underflow event from the pixel FIFO |
| sync_lost | input | 1 | Sync loss event from the timing logic |
| st_clr_we | input | 1 | Status clear strobe |
| st_clr_data | input | 10 | Status bits to clear |
| status | output | 10 | Status flags |
| irq | output | 1 | Interrupt |
| mem_req | output | 1 | Burst request |
| mem_addr | output | AW | First word address of the burst |
| mem_len | output | LW | Burst length in words |
| mem_gnt | input | 1 | Request accepted |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DW | Read data |
| fifo_push | output | 1 | FIFO write strobe |
| fifo_data | output | DW | FIFO write data |

## Verification
A request appears one cycle after enable is sampled high. It is accepted at the edge where the grant is sampled, and data beats follow from the next cycle. Each beat is pushed combinationally in the cycle it arrives. Status bits and their interrupts follow one edge after the final beat or event, and the interrupt follows an enable change with no delay. The bench drives stimulus on falling edges and reads status one falling edge after the event. It records pushes a quarter period before the rising edge that consumes each beat, and compares the recorded burst list and word stream with a list it builds itself from the region bounds.

// File: rtl/fb_fetch_seq.sv
module fb_fetch_seq #(
  parameter int AW        = 16,
  parameter int DW        = 32,
  parameter int LW        = 5,
  parameter int PAL_SHORT = 8,
  parameter int PAL_LONG  = 128
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_en,
  input  logic [1:0]    cfg_load_mode,
  input  logic [2:0]    cfg_burst,
  input  logic          cfg_dual,
  input  logic          cfg_pal8,
  input  logic          ie_pal,
  input  logic          ie_eof,
  input  logic          ie_urun,
  input  logic          ie_sync,
  input  logic [AW-1:0] pal_base,
  input  logic [AW-1:0] base0,
  input  logic [AW-1:0] ceil0,
  input  logic [AW-1:0] base1,
  input  logic [AW-1:0] ceil1,
  input  logic          fifo_underflow,
  input  logic          sync_lost,
  input  logic          st_clr_we,
  input  logic [9:0]    st_clr_data,
  output logic [9:0]    status,
  output logic          irq,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  output logic [LW-1:0] mem_len,
  input  logic          mem_gnt,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          fifo_push,
  output logic [DW-1:0] fifo_data
);

  localparam logic [2:0]    MAX_CODE  = 3'd4;
  localparam logic [AW-1:0] PAL_S_OFS = AW'(PAL_SHORT - 1);
  localparam logic [AW-1:0] PAL_L_OFS = AW'(PAL_LONG - 1);
  localparam int B_SYNC = 2, B_URUN = 5, B_PAL = 6, B_EOF0 = 8, B_EOF1 = 9;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_DATA, S_HOLD} state_t;
  typedef enum logic [1:0] {RG_PAL, RG_B0, RG_B1} region_t;

  state_t        st;
  region_t       rg, start_rg, nxt_rg, tgt_rg;
  logic          nxt_hold;
  logic [AW-1:0] addr, ceil_q, tgt_base, tgt_ceil;
  logic [LW-1:0] len_q, beat, bw, len_c;
  logic [AW-1:0] rem, end_addr;
  logic          burst_ok, last_beat, region_end;
  logic [9:0]    set_vec, clr_vec, ie_mask;

  assign burst_ok = cfg_burst <= MAX_CODE;
  assign bw       = LW'(1) << cfg_burst;
  assign rem      = ceil_q - addr;
  assign len_c    = (rem < AW'(bw) - AW'(1)) ? LW'(rem + AW'(1)) : bw;
  assign end_addr = addr + AW'(len_q) - AW'(1);

  assign last_beat  = (st == S_DATA) && mem_rvalid && (beat == len_q - LW'(1));
  assign region_end = last_beat && (end_addr == ceil_q);

  assign start_rg = cfg_load_mode[1] ? RG_B0 : RG_PAL;

  always_comb begin
    nxt_rg   = RG_B0;
    nxt_hold = 1'b0;
    case (rg)
      RG_PAL:  nxt_hold = (cfg_load_mode == 2'd1);
      RG_B0:   nxt_rg   = cfg_dual ? RG_B1 : RG_B0;
      default: nxt_rg   = RG_B0;
    endcase
  end

  assign tgt_rg = (st == S_IDLE) ? start_rg : nxt_rg;

  always_comb begin
    case (tgt_rg)
      RG_PAL: begin
        tgt_base = pal_base;
        tgt_ceil = pal_base + (cfg_pal8 ? PAL_L_OFS : PAL_S_OFS);
      end
      RG_B1: begin
        tgt_base = base1;
        tgt_ceil = ceil1;
      end
      default: begin
        tgt_base = base0;
        tgt_ceil = ceil0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      rg     <= RG_PAL;
      addr   <= '0;
      ceil_q <= '0;
      len_q  <= '0;
      beat   <= '0;
    end else if (!cfg_en) begin
      st <= S_IDLE;
    end else begin
      case (st)
        S_IDLE: if (burst_ok) begin
          rg     <= tgt_rg;
          addr   <= tgt_base;
          ceil_q <= tgt_ceil;
          st     <= S_REQ;
        end
        S_REQ: if (mem_gnt) begin
          len_q <= len_c;
          beat  <= '0;
          st    <= S_DATA;
        end
        S_DATA: if (mem_rvalid) begin
          beat <= beat + LW'(1);
          if (last_beat) begin
            if (!region_end) begin
              addr <= addr + AW'(len_q);
              st   <= S_REQ;
            end else if (nxt_hold) begin
              st <= S_HOLD;
            end else begin
              rg     <= tgt_rg;
              addr   <= tgt_base;
              ceil_q <= tgt_ceil;
              st     <= S_REQ;
            end
          end
        end
        default: st <= S_HOLD;
      endcase
    end
  end

  always_comb begin
    set_vec         = '0;
    set_vec[B_EOF0] = region_end && (rg == RG_B0);
    set_vec[B_EOF1] = region_end && (rg == RG_B1);
    set_vec[B_PAL]  = region_end && (rg == RG_PAL);
    set_vec[B_URUN] = fifo_underflow;
    set_vec[B_SYNC] = sync_lost;
    ie_mask         = '0;
    ie_mask[B_EOF0] = ie_eof;
    ie_mask[B_EOF1] = ie_eof;
    ie_mask[B_PAL]  = ie_pal;
    ie_mask[B_URUN] = ie_urun;
    ie_mask[B_SYNC] = ie_sync;
  end

  assign clr_vec = st_clr_we ? st_clr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= (status & ~clr_vec) | set_vec;
  end

  assign irq       = |(status & ie_mask);
  assign mem_req   = (st == S_REQ);
  assign mem_addr  = addr;
  assign mem_len   = len_c;
  assign fifo_push = (st == S_DATA) && mem_rvalid;
  assign fifo_data = mem_rdata;

  // R13
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt && cfg_en) |=> (mem_req && $stable(mem_addr) && $stable(mem_len)));

  // R11
  stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> (!mem_req && !fifo_push));

  // R4
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_len != '0) && (mem_len <= (LW'(1) << cfg_burst)));

  // R7
  sync_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lost |=> status[B_SYNC]);

  // R8
  urun_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_clr_we && st_clr_data[B_URUN] && !fifo_underflow) |=> !status[B_URUN]);

endmodule

// File: tb/fb_fetch_seq_bench.sv
module fb_fetch_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 16, DW = 32, LW = 5;
  localparam int RMAX = 2048, PMAX = 4096, EMAX = 64;
  localparam logic [15:0] PAL_AT = 16'h0C00;

  typedef struct packed {
    logic [1:0]  mode;
    logic [2:0]  code;
    logic        dual;
    logic        pal8;
    logic [15:0] b0;
    logic [15:0] c0;
    logic [15:0] b1;
    logic [15:0] c1;
    logic [7:0]  nreq;
    logic [9:0]  est;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{2'd0, 3'd2, 1'b0, 1'b0, 16'h0100, 16'h010A, 16'h0000, 16'h0000, 8'd8,  10'h140},
    '{2'd2, 3'd4, 1'b1, 1'b0, 16'h0200, 16'h0213, 16'h0300, 16'h0305, 8'd6,  10'h300},
    '{2'd1, 3'd3, 1'b0, 1'b1, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 8'd16, 10'h040},
    '{2'd0, 3'd0, 1'b1, 1'b0, 16'h0040, 16'h0041, 16'h0050, 16'h0050, 8'd13, 10'h340},
    '{2'd3, 3'd1, 1'b0, 1'b0, 16'h0010, 16'h0014, 16'h0000, 16'h0000, 8'd6,  10'h100}
  };

  logic clk = 0, rst_n = 0;
  logic cfg_en = 0, cfg_dual = 0, cfg_pal8 = 0;
  logic [1:0] cfg_load_mode = 0;
  logic [2:0] cfg_burst = 0;
  logic ie_pal = 0, ie_eof = 0, ie_urun = 0, ie_sync = 0;
  logic [AW-1:0] pal_base = PAL_AT, base0 = 0, ceil0 = 0, base1 = 0, ceil1 = 0;
  logic fifo_underflow = 0, sync_lost = 0, st_clr_we = 0;
  logic [9:0] st_clr_data = 0;
  logic [9:0] status;
  logic irq, mem_req, mem_gnt = 0, mem_rvalid = 0, fifo_push;
  logic [AW-1:0] mem_addr;
  logic [LW-1:0] mem_len;
  logic [DW-1:0] mem_rdata = 0, fifo_data;

  int errors = 0, checks = 0;
  int rec_n = 0, push_n = 0, left = 0, wait_c = 0;
  logic [AW-1:0] cur = 0;
  logic [AW-1:0] rec_a [RMAX];
  logic [LW-1:0] rec_l [RMAX];
  logic [DW-1:0] push_d [PMAX];
  logic [AW-1:0] exp_a [EMAX];
  int exp_l [EMAX];

  fb_fetch_seq #(.AW(AW), .DW(DW), .LW(LW)) u_fb_fetch_seq (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_load_mode(cfg_load_mode),
    .cfg_burst(cfg_burst), .cfg_dual(cfg_dual), .cfg_pal8(cfg_pal8),
    .ie_pal(ie_pal), .ie_eof(ie_eof), .ie_urun(ie_urun), .ie_sync(ie_sync),
    .pal_base(pal_base), .base0(base0), .ceil0(ceil0), .base1(base1), .ceil1(ceil1),
    .fifo_underflow(fifo_underflow), .sync_lost(sync_lost),
    .st_clr_we(st_clr_we), .st_clr_data(st_clr_data), .status(status), .irq(irq),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_len(mem_len), .mem_gnt(mem_gnt),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .fifo_push(fifo_push), .fifo_data(fifo_data));

  always #(CLK_PERIOD/2) clk = ~clk;

  // memory model: grant on the second falling edge of a request, then one beat per cycle
  always @(negedge clk) begin
    if (left > 0) begin
      mem_rvalid = 1; mem_rdata = 32'hA5A50000 | 32'(cur); cur = cur + 1; left = left - 1;
    end else mem_rvalid = 0;
    if (mem_gnt) mem_gnt = 0;
    else if (mem_req && left == 0) begin
      if (wait_c == 1) begin
        mem_gnt = 1; wait_c = 0;
        if (rec_n < RMAX) begin rec_a[rec_n] = mem_addr; rec_l[rec_n] = mem_len; rec_n = rec_n + 1; end
        left = int'(mem_len); cur = mem_addr;
      end else wait_c = wait_c + 1;
    end else wait_c = 0;
    #(CLK_PERIOD/4);
    if (fifo_push && push_n < PMAX) begin push_d[push_n] = fifo_data; push_n = push_n + 1; end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    int n, r, rb, pb, bad, k, total;
    logic [AW-1:0] a, b, c;
    int bl, l;
    bit stop;
    n = 0; r = (v.mode[1]) ? 1 : 0; stop = 0; bl = 1 << v.code;
    while (n < v.nreq && !stop) begin
      b = (r == 0) ? PAL_AT : (r == 1) ? v.b0 : v.b1;
      c = (r == 0) ? PAL_AT + (v.pal8 ? 16'd127 : 16'd7) : (r == 1) ? v.c0 : v.c1;
      a = b;
      while (a <= c && n < v.nreq) begin
        l = (int'(c - a) + 1 < bl) ? int'(c - a) + 1 : bl;
        exp_a[n] = a; exp_l[n] = l; n++; a = a + AW'(l);
      end
      if (r == 0) begin if (v.mode == 2'd1) stop = 1; r = 1; end
      else if (r == 1) r = v.dual ? 2 : 1;
      else r = 1;
    end
    @(negedge clk);
    cfg_load_mode = v.mode; cfg_burst = v.code; cfg_dual = v.dual; cfg_pal8 = v.pal8;
    base0 = v.b0; ceil0 = v.c0; base1 = v.b1; ceil1 = v.c1;
    rb = rec_n; pb = push_n;
    @(negedge clk); cfg_en = 1;
    for (int i = 0; i < 3000 && (rec_n - rb) < v.nreq; i++) @(negedge clk);
    cycles(40);
    // R2 R3 R4 R5 R10 R1: burst list
    bad = 0;
    for (int i = 0; i < v.nreq; i++)
      if (rec_a[rb+i] != exp_a[i] || int'(rec_l[rb+i]) != exp_l[i]) bad++;
    chk(bad == 0 && (rec_n - rb) >= v.nreq, $sformatf("R2/R4 vec%0d bursts", idx), bad, 0);
    // R2: pushed words follow the burst list in order
    bad = 0; k = 0; total = 0;
    for (int i = 0; i < v.nreq; i++) total += exp_l[i];
    for (int i = 0; i < v.nreq; i++)
      for (int j = 0; j < exp_l[i]; j++) begin
        if (push_d[pb+k] != (32'hA5A50000 | 32'(exp_a[i] + AW'(j)))) bad++;
        k++;
      end
    chk(bad == 0 && (push_n - pb) >= total, $sformatf("R2 vec%0d words", idx), bad, 0);
    // R1: palette-only mode holds after the palette
    if (v.mode == 2'd1) chk(rec_n - rb == v.nreq, "R1 palette-only hold", rec_n - rb, v.nreq);
    // R6
    chk(status == v.est, $sformatf("R6 vec%0d status", idx), status, v.est);
    cfg_en = 0;
    cycles(2);
    if (idx == 0) begin
      // R9: interrupt follows the enables
      ie_pal = 0; ie_eof = 0; #1;
      chk(irq == 0, "R9 irq masked", irq, 0);
      ie_eof = 1; #1;
      chk(irq == 1, "R9 irq eof", irq, 1);
      ie_eof = 0; ie_pal = 1; #1;
      chk(irq == 1, "R9 irq pal", irq, 1);
      ie_pal = 0;
    end
    @(negedge clk); st_clr_we = 1; st_clr_data = 10'h3FF;
    @(negedge clk); st_clr_we = 0; st_clr_data = 0;
    // R8
    chk(status == 0, $sformatf("R8 vec%0d clear all", idx), status, 0);
    cycles(30);
  endtask

  initial begin
    int rb, pb;
    cycles(3);
    // R12
    chk(status == 0, "R12 status", status, 0);
    chk(irq == 0, "R12 irq", irq, 0);
    chk(mem_req == 0, "R12 mem_req", mem_req, 0);
    chk(fifo_push == 0, "R12 fifo_push", fifo_push, 0);
    rst_n = 1;
    cycles(2);

    for (int i = 0; i < 5; i++) run_vec(VECS[i], i);

    // R3: invalid burst code issues nothing
    cfg_load_mode = 2'd2; cfg_burst = 3'd5; base0 = 16'h0100; ceil0 = 16'h0110;
    rb = rec_n;
    @(negedge clk); cfg_en = 1;
    cycles(20);
    chk(rec_n == rb && mem_req == 0, "R3 invalid code", rec_n - rb, 0);
    cfg_en = 0; cycles(3);

    // R11: no request before enable, stop on disable
    cfg_burst = 3'd4; base0 = 16'h0800; ceil0 = 16'h08FF;
    rb = rec_n;
    cycles(5);
    chk(rec_n == rb, "R11 idle before enable", rec_n - rb, 0);
    cfg_en = 1;
    cycles(30);
    cfg_en = 0;
    @(negedge clk); #3;
    chk(mem_req == 0, "R11 request dropped", mem_req, 0);
    pb = push_n;
    cycles(20);
    chk(push_n == pb, "R11 no push after stop", push_n - pb, 0);

    // R7: event inputs set their bits
    @(negedge clk); fifo_underflow = 1;
    @(negedge clk); fifo_underflow = 0;
    chk(status[5] == 1, "R7 underflow bit", status[5], 1);
    ie_urun = 1; #1;
    chk(irq == 1, "R9 irq underflow", irq, 1);
    ie_urun = 0;
    // R8: set wins over clear in the same cycle
    @(negedge clk); sync_lost = 1; st_clr_we = 1; st_clr_data = 10'h004;
    @(negedge clk); sync_lost = 0; st_clr_we = 0; st_clr_data = 0;
    chk(status[2] == 1, "R8 set beats clear", status[2], 1);
    chk(status[5] == 1, "R7 underflow kept", status[5], 1);
    // R8: clear touches only the written bit
    @(negedge clk); st_clr_we = 1; st_clr_data = 10'h020;
    @(negedge clk); st_clr_we = 0; st_clr_data = 0;
    chk(status == 10'h004, "R8 selective clear", status, 10'h004);
    ie_sync = 1; #1;
    chk(irq == 1, "R9 irq sync", irq, 1);
    ie_sync = 0; #1;
    chk(irq == 0, "R9 irq sync masked", irq, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule